// File: doc/BRIEF.md
# One-Bit Button Calculator Controller

This block is a small synchronous controller for a calculator with four push buttons: a zero digit, a one digit, an Add key and an Equals key. Each button arrives as a single-cycle pulse. The controller keeps two operand registers, `opnd_a` and `opnd_b`, a phase register and a registered result. It steps through first-operand entry, operator entry, second-operand entry and result display. From the result display, a new digit starts the next calculation.

The phase register has three named states. `PH_FIRST` (code 2'b00) means the first operand is being entered. `PH_OPER` (code 2'b01) means an add has been requested and the second operand is being entered. `PH_DONE` (code 2'b10) means a result is shown.

The named transitions are as follows:
- `T_FIRST_DIGIT`: `PH_FIRST` to `PH_FIRST`; the digit is loaded into A.
- `T_FIRST_ADD`: `PH_FIRST` to `PH_OPER`.
- `T_OPER_DIGIT`: `PH_OPER` to `PH_OPER`; the digit is loaded into B.
- `T_OPER_EQ`: `PH_OPER` to `PH_DONE`; the sum is latched.
- `T_DONE_DIGIT`: `PH_DONE` to `PH_FIRST`; the digit is loaded into A and B is cleared.

Every other button event leaves all state unchanged. Reset is synchronous and active high. All outputs are registered and change at the clock edge that samples the button pulse.

Top module: `calc1b_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `opnd_a`=0, `opnd_b`=0, `phase`=2'b00 and `sum_out`=0.
- R2: In phase 2'b00, a lone `key_zero` or `key_one` pulse loads 0 or 1 into `opnd_a`. `opnd_b`, `phase` and `sum_out` keep their values.
- R3: In phase 2'b00, a lone `key_add` pulse sets `phase` to 2'b01. `opnd_a`, `opnd_b` and `sum_out` keep their values.
- R4: In phase 2'b01, a lone digit pulse loads that digit into `opnd_b`. `opnd_a` and `phase` keep their values.
- R5: In phase 2'b01, a lone `key_eq` pulse sets `sum_out` to the 2-bit sum `opnd_a`+`opnd_b`, so 1+1 gives 2'b10. It sets `phase` to 2'b10 and leaves both operands unchanged.
- R6: In phase 2'b10, a lone digit pulse loads that digit into `opnd_a`, clears `opnd_b` and sets `phase` to 2'b00. `sum_out` keeps its value.
- R7: A clock with two or more key inputs high changes no output.
- R8: A lone `key_eq` in phase 2'b00 or 2'b10 changes no output. So does a lone `key_add` in phase 2'b01 or 2'b10.
- R9: `sum_out` changes only through R5 or reset. A clock with no key high changes no output. `phase` never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_zero | input | 1 | Digit 0 button pulse |
| key_one | input | 1 | Digit 1 button pulse |
| key_add | input | 1 | Add button pulse |
| key_eq | input | 1 | Equals button pulse |
| opnd_a | output | DIGIT_W (1) | First operand |
| opnd_b | output | DIGIT_W (1) | Second operand |
| phase | output | 2 | 00 first entry, 01 add pending, 10 result shown |
| sum_out | output | DIGIT_W+1 (2) | Registered sum |

## Verification
The assertions assume that key inputs are sampled only at rising edges and are settled before each edge. They do not assume one key per cycle: overlapping presses are legal input that the block must ignore. The bench changes keys only on falling edges. Its random stream deliberately includes two-key overlaps, idle cycles, out-of-order Add and Equals presses, and occasional resets mid-calculation, so that every ignore path is exercised within the stated input contract.

// File: rtl/calc1b_pkg.sv
package calc1b_pkg;

    typedef enum logic [1:0] {
        PH_FIRST = 2'b00,
        PH_OPER  = 2'b01,
        PH_DONE  = 2'b10
    } phase_t;

    typedef enum logic [2:0] {
        EV_NONE = 3'd0,
        EV_DIG0 = 3'd1,
        EV_DIG1 = 3'd2,
        EV_ADD  = 3'd3,
        EV_EQ   = 3'd4
    } key_ev_t;

    localparam int NUM_KEYS = 4;

endpackage

// File: rtl/calc1b_key_decode.sv
module calc1b_key_decode
    import calc1b_pkg::*;
(
    input  logic                key_zero,
    input  logic                key_one,
    input  logic                key_add,
    input  logic                key_eq,
    output key_ev_t             ev
);

    logic [NUM_KEYS-1:0] keys;
    logic                lone;

    assign keys = {key_eq, key_add, key_one, key_zero};

    // A key counts only when it is the sole key high in the cycle (R7).
    always_comb begin
        lone = 1'b0;
        for (int i = 0; i < NUM_KEYS; i++) begin
            if (keys == (NUM_KEYS'(1) << i)) begin
                lone = 1'b1;
            end
        end
    end

    always_comb begin
        ev = EV_NONE;
        if (lone) begin
            unique case (1'b1)
                key_zero: ev = EV_DIG0;
                key_one:  ev = EV_DIG1;
                key_add:  ev = EV_ADD;
                key_eq:   ev = EV_EQ;
                default:  ev = EV_NONE;
            endcase
        end
    end

endmodule

// File: rtl/calc1b_phase_fsm.sv
module calc1b_phase_fsm
    import calc1b_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  key_ev_t ev,
    output phase_t  ph,
    output logic    load_a,
    output logic    load_b,
    output logic    clr_b,
    output logic    take_sum
);

    phase_t ph_q;
    phase_t ph_d;
    logic   is_digit;

    assign is_digit = (ev == EV_DIG0) || (ev == EV_DIG1);

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_FIRST;
        end else begin
            ph_q <= ph_d;
        end
    end

    // Next state and action strobes.
    always_comb begin
        ph_d     = ph_q;
        load_a   = 1'b0;
        load_b   = 1'b0;
        clr_b    = 1'b0;
        take_sum = 1'b0;
        unique case (ph_q)
            PH_FIRST: begin
                if (is_digit) begin            // T_FIRST_DIGIT
                    load_a = 1'b1;
                end else if (ev == EV_ADD) begin // T_FIRST_ADD
                    ph_d = PH_OPER;
                end
            end
            PH_OPER: begin
                if (is_digit) begin            // T_OPER_DIGIT
                    load_b = 1'b1;
                end else if (ev == EV_EQ) begin  // T_OPER_EQ
                    take_sum = 1'b1;
                    ph_d     = PH_DONE;
                end
            end
            PH_DONE: begin
                if (is_digit) begin            // T_DONE_DIGIT
                    load_a = 1'b1;
                    clr_b  = 1'b1;
                    ph_d   = PH_FIRST;
                end
            end
            default: ph_d = PH_FIRST;
        endcase
    end

    assign ph = ph_q;

endmodule

// File: rtl/calc1b_operand_regs.sv
module calc1b_operand_regs
    import calc1b_pkg::*;
#(
    parameter int DIGIT_W = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  key_ev_t            ev,
    input  logic               load_a,
    input  logic               load_b,
    input  logic               clr_b,
    output logic [DIGIT_W-1:0] a_q,
    output logic [DIGIT_W-1:0] b_q
);

    logic [DIGIT_W-1:0] digit_val;

    assign digit_val = (ev == EV_DIG1) ? DIGIT_W'(1) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            if (load_a) begin
                a_q <= digit_val;
            end
            if (clr_b) begin
                b_q <= '0;
            end else if (load_b) begin
                b_q <= digit_val;
            end
        end
    end

endmodule

// File: rtl/calc1b_sum_reg.sv
module calc1b_sum_reg #(
    parameter int DIGIT_W = 1,
    localparam int SUM_W = DIGIT_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               take_sum,
    input  logic [DIGIT_W-1:0] a_in,
    input  logic [DIGIT_W-1:0] b_in,
    output logic [SUM_W-1:0]   sum_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
        end else if (take_sum) begin
            sum_q <= SUM_W'(a_in) + SUM_W'(b_in);
        end
    end

endmodule

// File: rtl/calc1b_ctrl.sv
module calc1b_ctrl
    import calc1b_pkg::*;
#(
    parameter int DIGIT_W = 1,
    localparam int SUM_W = DIGIT_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               key_zero,
    input  logic               key_one,
    input  logic               key_add,
    input  logic               key_eq,
    output logic [DIGIT_W-1:0] opnd_a,
    output logic [DIGIT_W-1:0] opnd_b,
    output logic [1:0]         phase,
    output logic [SUM_W-1:0]   sum_out
);

    key_ev_t ev;
    phase_t  ph;
    logic    load_a;
    logic    load_b;
    logic    clr_b;
    logic    take_sum;

    calc1b_key_decode u_dec (
        .key_zero (key_zero),
        .key_one  (key_one),
        .key_add  (key_add),
        .key_eq   (key_eq),
        .ev       (ev)
    );

    calc1b_phase_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .ph       (ph),
        .load_a   (load_a),
        .load_b   (load_b),
        .clr_b    (clr_b),
        .take_sum (take_sum)
    );

    calc1b_operand_regs #(.DIGIT_W(DIGIT_W)) u_ops (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .load_a (load_a),
        .load_b (load_b),
        .clr_b  (clr_b),
        .a_q    (opnd_a),
        .b_q    (opnd_b)
    );

    calc1b_sum_reg #(.DIGIT_W(DIGIT_W)) u_sum (
        .clk      (clk),
        .rst      (rst),
        .take_sum (take_sum),
        .a_in     (opnd_a),
        .b_in     (opnd_b),
        .sum_q    (sum_out)
    );

    assign phase = ph;

endmodule

// File: rtl/calc1b_ctrl_chk.sv
module calc1b_ctrl_chk #(
    parameter int DIGIT_W = 1,
    localparam int SUM_W = DIGIT_W + 1
) (
    input logic               clk,
    input logic               rst,
    input logic               key_zero,
    input logic               key_one,
    input logic               key_add,
    input logic               key_eq,
    input logic [DIGIT_W-1:0] opnd_a,
    input logic [DIGIT_W-1:0] opnd_b,
    input logic [1:0]         phase,
    input logic [SUM_W-1:0]   sum_out
);

    logic [3:0] keys;
    logic       only_add;
    logic       only_eq;
    logic       multi;

    assign keys     = {key_eq, key_add, key_one, key_zero};
    assign only_add = (keys == 4'b0100);
    assign only_eq  = (keys == 4'b1000);
    assign multi    = ($countones(keys) > 1);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (opnd_a == '0 && opnd_b == '0 && phase == 2'b00 && sum_out == '0));

    p_add_enters_oper_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'b00 && only_add) |=> (phase == 2'b01 && $stable(opnd_a)));

    p_eq_sum_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'b01 && only_eq) |=>
            (sum_out == SUM_W'($past(opnd_a)) + SUM_W'($past(opnd_b)) && phase == 2'b10));

    p_multi_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        multi |=> ($stable(opnd_a) && $stable(opnd_b) && $stable(phase) && $stable(sum_out)));

    p_late_add_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (phase != 2'b00 && only_add) |=> ($stable(phase) && $stable(opnd_b)));

    p_sum_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(phase == 2'b01 && only_eq) |=> $stable(sum_out));

    p_phase_legal_r9: assert property (@(posedge clk) disable iff (rst)
        phase != 2'b11);

endmodule

bind calc1b_ctrl calc1b_ctrl_chk #(.DIGIT_W(DIGIT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .key_zero (key_zero),
    .key_one  (key_one),
    .key_add  (key_add),
    .key_eq   (key_eq),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .phase    (phase),
    .sum_out  (sum_out)
);

// File: tb/calc1b_ctrl_tb.sv
`timescale 1ns/1ps
module calc1b_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       key_zero = 1'b0;
    logic       key_one = 1'b0;
    logic       key_add = 1'b0;
    logic       key_eq = 1'b0;
    logic [0:0] opnd_a;
    logic [0:0] opnd_b;
    logic [1:0] phase;
    logic [1:0] sum_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state.
    logic [0:0] m_a;
    logic [0:0] m_b;
    logic [1:0] m_ph;
    logic [1:0] m_sum;

    // Key codes: 0 digit0, 1 digit1, 2 add, 3 equals, 4 two keys, 5 idle.
    localparam int K_D0 = 0, K_D1 = 1, K_ADD = 2, K_EQ = 3, K_MULTI = 4, K_IDLE = 5;

    always #5 clk = ~clk;

    calc1b_ctrl u_dut (
        .clk      (clk),
        .rst      (rst),
        .key_zero (key_zero),
        .key_one  (key_one),
        .key_add  (key_add),
        .key_eq   (key_eq),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .phase    (phase),
        .sum_out  (sum_out)
    );

    function automatic string req_of(input int code, input logic [1:0] ph);
        case (code)
            K_D0, K_D1: return (ph == 2'b00) ? "R2" : (ph == 2'b01) ? "R4" : "R6";
            K_ADD:      return (ph == 2'b00) ? "R3" : "R8";
            K_EQ:       return (ph == 2'b01) ? "R5" : "R8";
            K_MULTI:    return "R7";
            default:    return "R9";
        endcase
    endfunction

    task automatic model_step(input int code);
        case (code)
            K_D0, K_D1: begin
                if (m_ph == 2'b00) begin
                    m_a = (code == K_D1);
                end else if (m_ph == 2'b01) begin
                    m_b = (code == K_D1);
                end else begin
                    m_a  = (code == K_D1);
                    m_b  = 1'b0;
                    m_ph = 2'b00;
                end
            end
            K_ADD: if (m_ph == 2'b00) m_ph = 2'b01;
            K_EQ: if (m_ph == 2'b01) begin
                m_sum = {1'b0, m_a} + {1'b0, m_b};
                m_ph  = 2'b10;
            end
            default: ;
        endcase
    endtask

    task automatic compare(input string tag);
        checks++;
        if (opnd_a !== m_a || opnd_b !== m_b || phase !== m_ph || sum_out !== m_sum) begin
            errors++;
            $display("FAIL %s actual a=%0d b=%0d ph=%0d sum=%0d expected a=%0d b=%0d ph=%0d sum=%0d",
                     tag, opnd_a, opnd_b, phase, sum_out, m_a, m_b, m_ph, m_sum);
        end
    endtask

    task automatic press(input int code);
        string tag;
        @(negedge clk);
        key_zero = (code == K_D0);
        key_one  = (code == K_D1) || (code == K_MULTI);
        key_add  = (code == K_ADD) || (code == K_MULTI);
        key_eq   = (code == K_EQ);
        tag = req_of(code, m_ph);
        model_step(code);
        @(negedge clk);
        key_zero = 1'b0;
        key_one  = 1'b0;
        key_add  = 1'b0;
        key_eq   = 1'b0;
        compare(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_a = 1'b0; m_b = 1'b0; m_ph = 2'b00; m_sum = 2'b00;
        compare("R1");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd1234);
        do_reset();

        // All four operand pairs, with R5 result checks.
        for (int a = 0; a < 2; a++) begin
            for (int b = 0; b < 2; b++) begin
                do_reset();
                press(a ? K_D1 : K_D0);
                press(K_ADD);
                press(b ? K_D1 : K_D0);
                press(K_EQ);
            end
        end

        // Chained calculations starting from a shown result (R6).
        press(K_D1); press(K_ADD); press(K_D1); press(K_EQ);
        press(K_D0); press(K_ADD); press(K_D1); press(K_EQ);

        // Out-of-order and overlapping presses (R7, R8).
        do_reset();
        press(K_EQ); press(K_D1); press(K_MULTI); press(K_ADD);
        press(K_ADD); press(K_D1); press(K_MULTI); press(K_EQ);
        press(K_ADD); press(K_EQ); press(K_IDLE);

        // Reset mid-calculation clears the shown sum (R1, R9).
        press(K_D1); press(K_ADD);
        do_reset();

        // Constrained random stream.
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 2) begin
                do_reset();
            end else begin
                press(int'($urandom_range(0, 5)));
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule